// File: doc/BRIEF.md
# Driver Fault Protection Supervisor

This block watches the protection inputs of an eight-channel low-side driver. It decides which channels must be forced off. Each channel has its own overcurrent comparator flag. A flag must stay high for a programmable number of clock cycles before it counts as a real fault. Once a fault is accepted, it is held until the output-enable/reset input rises or the supply drops into lockout. Only the faulted channel is forced off.

Two shared conditions can force every channel off at once: die over-temperature and supply undervoltage. The die temperature arrives as a code in whole degrees Celsius. The supply arrives as a code in millivolts. Each condition is compared against a pair of thresholds with hysteresis, so it does not chatter near the limit. Neither condition is held once it clears. The output register downstream uses the per-channel mask and the global disable to gate its drivers.

Top module: `drv_fault_sup`

## Requirements
- R1: After reset, `ch_off` is 0, `hot_stat` is 0, `uv_stat` is 1 (the block starts in supply lockout) and `all_off` is 1.
- R2: A channel's fault bit sets only after that channel's `oc_raw` bit has been high on FLT_CYC consecutive rising clock edges. The bit is visible right after the FLT_CYC-th such edge. If the flag goes low after FLT_CYC-1 edges, no fault is recorded.
- R3: A low sample of a channel's flag restarts that channel's count from zero. Bit n of `oc_raw` drives only bit n of `ch_off`.
- R4: Once set, a fault bit stays set while `oe_rst` does not rise and `uv_stat` stays 0, whether or not the flag is still high.
- R5: A rising edge of `oe_rst` clears every fault bit on the edge where it is first sampled high. Holding `oe_rst` high clears nothing further.
- R6: After a clear, a flag that stays high must pass the full FLT_CYC edges again before its fault bit sets.
- R7: `hot_stat` sets on the edge after `temp_c` is sampled at or above 165. It clears only once `temp_c` is sampled at or below 154, which is more than 10 degrees under the trip point.
- R8: `uv_stat` sets on the edge after `vdd_mv` is sampled below 3500. It clears only once `vdd_mv` is sampled at or above 4000.
- R9: `all_off` equals `hot_stat | uv_stat`.
- R10: While `uv_stat` is 1, every fault bit is cleared and every filter count is held at zero. A lockout followed by recovery therefore acts as a power cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 8 | Raw overcurrent flag per channel, high = overcurrent |
| temp_c | input | 8 | Die temperature code, degrees Celsius |
| vdd_mv | input | 13 | Logic supply code, millivolts |
| oe_rst | input | 1 | Output-enable/reset input; its rising edge clears faults |
| ch_off | output | 8 | Latched per-channel overcurrent fault mask |
| all_off | output | 1 | Global disable: thermal or undervoltage |
| hot_stat | output | 1 | Thermal shutdown active |
| uv_stat | output | 1 | Undervoltage lockout active |

## Verification
The overcurrent filter gets three kinds of pulse:
- one edge shorter than the filter length;
- exactly the filter length;
- an almost-full pulse with a one-cycle dropout, which shows whether the count restarts or only pauses.

Two channels driven at once, with different patterns, show whether the channels are independent. A clear is issued while a flag is still high, to tell a full re-filter apart from an immediate re-fault. Holding `oe_rst` high tells edge clearing apart from level clearing. The temperature and supply codes are stepped onto the values just inside and just outside each threshold, in both directions, to pin down the exact hysteresis band.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  // Next state of a hysteretic flag: set wins, then clear, else hold.
  function automatic logic hyst_next(input logic cur, input logic go_on, input logic go_off);
    if (go_on)       return 1'b1;
    else if (go_off) return 1'b0;
    else             return cur;
  endfunction

  // Filter terminal hit: flag high while count already holds limit-1.
  function automatic logic filt_hit(input logic flag, input int unsigned cnt, input int unsigned lim);
    return flag && (cnt == lim - 1);
  endfunction
endpackage

// File: rtl/oc_channel.sv
module oc_channel
  import drv_fault_pkg::*;
#(
  parameter int unsigned FLT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic clr,
  output logic fault
);
  localparam int CW = $clog2(FLT_CYC + 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = filt_hit(flag, int'(cnt), FLT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      if (!flag)                          cnt <= '0;
      else if (cnt != CW'(FLT_CYC - 1))   cnt <= cnt + 1'b1;
      if (hit) fault <= 1'b1;
    end
  end

  // R2
  fault_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(flag));
  // R4
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr |=> fault);
  // R5
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault);
endmodule

// File: rtl/prot_hyst.sv
module prot_hyst
  import drv_fault_pkg::*;
#(
  parameter int W         = 8,
  parameter int ON_LVL    = 165,
  parameter int OFF_LVL   = 155,
  parameter bit HIGH_TRIP = 1'b1,
  parameter bit INIT      = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         active
);
  localparam logic [W-1:0] ON_V  = ON_LVL[W-1:0];
  localparam logic [W-1:0] OFF_V = OFF_LVL[W-1:0];

  logic go_on, go_off;

  generate
    if (HIGH_TRIP) begin : g_over
      assign go_on  = level >= ON_V;
      assign go_off = level <  OFF_V;
    end else begin : g_under
      assign go_on  = level <  ON_V;
      assign go_off = level >= OFF_V;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= INIT;
    else        active <= hyst_next(active, go_on, go_off);
  end

  // R7 R8
  trip_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_on |=> active);
  // R7 R8
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !go_off |=> active);
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup #(
  parameter int NCH        = 8,
  parameter int TW         = 8,
  parameter int VW         = 13,
  parameter int FLT_CYC    = 100,
  parameter int HOT_TRIP_C = 165,
  parameter int HOT_HYST_C = 10,
  parameter int UV_ON_MV   = 3500,
  parameter int UV_OFF_MV  = 4000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_raw,
  input  logic [TW-1:0]  temp_c,
  input  logic [VW-1:0]  vdd_mv,
  input  logic           oe_rst,
  output logic [NCH-1:0] ch_off,
  output logic           all_off,
  output logic           hot_stat,
  output logic           uv_stat
);
  localparam int HOT_REL_C = HOT_TRIP_C - HOT_HYST_C;

  logic oe_q;
  logic oe_rise;
  logic flt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_rst;
  end

  assign oe_rise = oe_rst && !oe_q;
  assign flt_clr = oe_rise || uv_stat;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      oc_channel #(.FLT_CYC(FLT_CYC)) u_ch (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (oc_raw[i]),
        .clr   (flt_clr),
        .fault (ch_off[i])
      );
    end
  endgenerate

  prot_hyst #(.W(TW), .ON_LVL(HOT_TRIP_C), .OFF_LVL(HOT_REL_C),
              .HIGH_TRIP(1'b1), .INIT(1'b0)) u_hot (
    .clk(clk), .rst_n(rst_n), .level(temp_c), .active(hot_stat));

  prot_hyst #(.W(VW), .ON_LVL(UV_ON_MV), .OFF_LVL(UV_OFF_MV),
              .HIGH_TRIP(1'b0), .INIT(1'b1)) u_uv (
    .clk(clk), .rst_n(rst_n), .level(vdd_mv), .active(uv_stat));

  assign all_off = hot_stat | uv_stat;

  // R10
  lockout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_stat |=> ch_off == '0);
  // R5
  held_oe_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_rst) && oe_rst && !uv_stat && ch_off != '0 |=> ch_off != '0);
  // R9
  global_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_off == (hot_stat || uv_stat));
endmodule

// File: tb/test_drv_fault_sup.sv
module test_drv_fault_sup;
  localparam int F = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] oc_raw = '0;
  logic [7:0] temp_c = 8'd25;
  logic [12:0] vdd_mv = 13'd0;
  logic       oe_rst = 1'b0;
  logic [7:0] ch_off;
  logic       all_off, hot_stat, uv_stat;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  drv_fault_sup i_drv_fault_sup (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .temp_c(temp_c), .vdd_mv(vdd_mv),
    .oe_rst(oe_rst), .ch_off(ch_off), .all_off(all_off), .hot_stat(hot_stat),
    .uv_stat(uv_stat));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 ch_off", 32'(ch_off), 0);
    chk("R1 hot", 32'(hot_stat), 0);
    chk("R1 uv", 32'(uv_stat), 1);
    chk("R1 all_off", 32'(all_off), 1);
    vdd_mv = 13'd5000; tick(1);
    chk("R8 release", 32'(uv_stat), 0);
    chk("R9 all_off low", 32'(all_off), 0);
  endtask

  task automatic t_filter;
    oc_raw = 8'h01; tick(F - 1); oc_raw = 8'h00; tick(1);
    chk("R2 short pulse", 32'(ch_off), 0);
    oc_raw = 8'h01; tick(F - 2); oc_raw = 8'h00; tick(1);
    oc_raw = 8'h01; tick(2);
    chk("R3 restart after dropout", 32'(ch_off), 0);
    tick(F - 3);
    chk("R2 one edge early", 32'(ch_off), 0);
    tick(1);
    chk("R2 full length sets ch0", 32'(ch_off), 32'h01);
    oc_raw = 8'h00; tick(5);
    chk("R4 holds after flag low", 32'(ch_off), 32'h01);
  endtask

  task automatic t_indep;
    oc_raw = 8'h90; tick(F);
    chk("R3 ch7 ch4 only", 32'(ch_off), 32'h91);
    oc_raw = 8'h00;
  endtask

  task automatic t_clear;
    oc_raw = 8'h10;
    oe_rst = 1'b1; tick(1);
    chk("R5 rise clears", 32'(ch_off), 0);
    tick(F - 1);
    chk("R6 refilter not yet", 32'(ch_off), 0);
    tick(1);
    chk("R6 refault after full filter", 32'(ch_off), 32'h10);
    tick(3);
    chk("R5 held high no clear", 32'(ch_off), 32'h10);
    oe_rst = 1'b0; oc_raw = 8'h00; tick(1);
    chk("R4 oe fall no effect", 32'(ch_off), 32'h10);
  endtask

  task automatic t_thermal;
    temp_c = 8'd164; tick(1);
    chk("R7 below trip", 32'(hot_stat), 0);
    temp_c = 8'd165; tick(1);
    chk("R7 trip", 32'(hot_stat), 1);
    chk("R9 all_off hot", 32'(all_off), 1);
    chk("R7 mask untouched", 32'(ch_off), 32'h10);
    temp_c = 8'd155; tick(1);
    chk("R7 hold at 155", 32'(hot_stat), 1);
    temp_c = 8'd154; tick(1);
    chk("R7 release at 154", 32'(hot_stat), 0);
    chk("R9 all_off cleared", 32'(all_off), 0);
    temp_c = 8'd25;
  endtask

  task automatic t_uv;
    vdd_mv = 13'd3500; tick(1);
    chk("R8 3500 not lockout", 32'(uv_stat), 0);
    chk("R10 fault kept", 32'(ch_off), 32'h10);
    vdd_mv = 13'd3499; tick(1);
    chk("R8 engage", 32'(uv_stat), 1);
    tick(1);
    chk("R10 lockout clears faults", 32'(ch_off), 0);
    oc_raw = 8'h02; tick(F + 5);
    chk("R10 no fault in lockout", 32'(ch_off), 0);
    vdd_mv = 13'd3999; tick(1);
    chk("R8 hold at 3999", 32'(uv_stat), 1);
    vdd_mv = 13'd4000; tick(1);
    chk("R8 release at 4000", 32'(uv_stat), 0);
    tick(F - 1);
    chk("R10 count started at zero", 32'(ch_off), 0);
    tick(1);
    chk("R10 fault after recovery", 32'(ch_off), 32'h02);
    oc_raw = 8'h00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_filter();
    t_indep();
    oe_rst = 1'b1; tick(1); oe_rst = 1'b0; tick(1);
    chk("R5 clear all", 32'(ch_off), 0);
    oc_raw = 8'h10; tick(F); oc_raw = 8'h00;
    t_clear();
    t_thermal();
    t_uv();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule